// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end between a 16-bit processor bus and the program/erase controller of an on-chip flash. It watches bus writes into the user flash window and decodes the one-cycle and two-cycle command sequences. For each completed operation it issues a one-cycle request strobe to the back end, with the captured address, data word or block selection. It also keeps a read mode, and that mode decides whether bus reads return array words, the status byte or a block's lock bit.

Only the low byte of a command write is decoded. Erase and lock operations need a confirm byte in their second write. If a sequence is broken, no request goes out and error bits are set in the status byte. The back end reports busy and failure. While it is busy, command writes are dropped, and the status byte's ready bit shows the busy state.

The flash window is split into `NUM_BLK` equal blocks of `2**BLK_SHIFT` bytes. Block `PROT_BLK` is protected: it is left out of the bulk erase and can be erased only by a block erase aimed at it.

Top module: `flash_cmd_if`

## Requirements
- R1: Writes and reads at odd byte addresses, or at addresses whose block index is `NUM_BLK` or above, are ignored: they change no state and produce no `rd_valid`.
- R2: Only `bus_wdata[7:0]` is decoded as a command or confirm code. Bits 15:8 never change how a code is decoded.
- R3: After reset, and after code 0xFF, every accepted read returns the array word `arr_rdata` on `rd_data` one cycle later with `rd_valid` high. The mode holds over any number of reads.
- R4: Code 0x70 selects status mode. Reads then return `{8'h00, status}`, where status bit 7 is ready (not busy), bit 5 is the erase error, bit 4 is the program error, and the other bits are 0.
- R5: `be_prog_fail` and `be_erase_fail` set the sticky program error bit and erase error bit, which are mirrored on `err_flags` as {erase, program}. Code 0x50 clears both bits in one cycle and leaves the read mode unchanged.
- R6: Code 0x40 followed by a write to the same address gives one `req_prog` pulse carrying that address and the full 16-bit word. A second write to any other address sets only the program error bit and issues no request.
- R7: Code 0x20 followed by confirm 0xD0 gives one `req_blk_erase` pulse, with `req_blk` set to the block of the confirm address. This also works for the protected block.
- R8: Code 0x77 followed by confirm 0xD0 gives one `req_lock_prog` pulse, with the block and address of the confirm write.
- R9: Code 0xA7 followed by confirm 0xD0 gives one `req_erase_all` pulse. Its `erase_mask` has a bit set for every block that is unlocked and is not `PROT_BLK`.
- R10: In an erase, bulk-erase or lock sequence, a second write whose low byte is not 0xD0 sets both error bits, issues no request and selects read-array mode.
- R11: Code 0x71 selects lock mode. Reads then return `{15'b0, lock_bits[block]}` for the block that contains the read address.
- R12: While `be_busy` is high, every command write, including a second cycle, is ignored, and the status ready bit reads 0.
- R13: Writes of undefined first-cycle codes, including a lone 0xD0, are ignored and leave the read mode unchanged.
- R14: When any two-cycle sequence completes, whether or not it issues a request, the read mode becomes read-array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte address inside the flash window |
| bus_wdata | input | 16 | Bus write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 16 | Read data selected by the read mode |
| arr_raddr | output | ADDR_W | Address presented to the array read port |
| arr_rdata | input | 16 | Array word at `arr_raddr`, same cycle |
| lock_bits | input | NUM_BLK | Lock bit per block, 1 = locked |
| be_busy | input | 1 | Back end operation in progress |
| be_prog_fail | input | 1 | Back end program failure pulse |
| be_erase_fail | input | 1 | Back end erase failure pulse |
| req_prog | output | 1 | Program request pulse |
| req_blk_erase | output | 1 | Block erase request pulse |
| req_lock_prog | output | 1 | Lock-bit program request pulse |
| req_erase_all | output | 1 | Erase-all-unlocked request pulse |
| req_addr | output | ADDR_W | Address of the request |
| req_blk | output | BIDX_W | Block index of the request |
| req_data | output | 16 | Program data word |
| erase_mask | output | NUM_BLK | Blocks to erase for the bulk erase |
| err_flags | output | 2 | Sticky error bits {erase, program} |

## Verification
The bench builds the block with `NUM_BLK=6` and `BLK_SHIFT=4`, so there are 16-byte blocks and a 7-bit address. Because six is not a power of two, block indices 6 and 7 can be formed on the bus but do not exist. That lets the bench check that writes outside the window are dropped. With so few blocks, a single lock pattern can exercise the bulk-erase mask, the protected top block and the per-block lock read, using short address sequences.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_LOCK} rd_mode_e;
  typedef enum logic [2:0] {PD_NONE, PD_PROG, PD_BERASE, PD_LOCK, PD_EALL} pend_e;

  localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_RD_LOCK  = 8'h71;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_BERASE   = 8'h20;
  localparam logic [7:0] OP_LOCKPROG = 8'h77;
  localparam logic [7:0] OP_EALL     = 8'hA7;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
endpackage

// File: rtl/flash_addr_dec.sv
module flash_addr_dec #(
  parameter int NUM_BLK   = 14,
  parameter int BLK_SHIFT = 8,
  parameter int BIDX_W    = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok,
  output logic [BIDX_W-1:0] blk
);
  localparam logic [BIDX_W:0] BLK_LIMIT = (BIDX_W+1)'(NUM_BLK);

  assign blk = addr[ADDR_W-1:BLK_SHIFT];
  assign ok  = !addr[0] && ({1'b0, blk} < BLK_LIMIT);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK  = 14,
  parameter int BIDX_W   = 4,
  parameter int ADDR_W   = 12,
  parameter int PROT_BLK = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               wr_ok,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BIDX_W-1:0]  blk,
  input  logic [15:0]        wdata,
  input  logic               busy,
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic               prog_fail,
  input  logic               erase_fail,
  output rd_mode_e           mode,
  output logic               err_prog,
  output logic               err_erase,
  output logic               req_prog,
  output logic               req_blk_erase,
  output logic               req_lock_prog,
  output logic               req_erase_all,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BIDX_W-1:0]  req_blk,
  output logic [15:0]        req_data,
  output logic [NUM_BLK-1:0] erase_mask
);
  localparam logic [NUM_BLK-1:0] PROT_MASK = NUM_BLK'(1) << PROT_BLK;

  pend_e              pend_q;
  logic [ADDR_W-1:0]  pend_addr_q;
  logic [7:0]         code;
  logic               accept;
  logic [NUM_BLK-1:0] eligible;

  assign code     = wdata[7:0];
  assign accept   = wr && wr_ok && !busy;
  assign eligible = ~lock_bits & ~PROT_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode          <= RM_ARRAY;
      pend_q        <= PD_NONE;
      pend_addr_q   <= '0;
      err_prog      <= 1'b0;
      err_erase     <= 1'b0;
      req_prog      <= 1'b0;
      req_blk_erase <= 1'b0;
      req_lock_prog <= 1'b0;
      req_erase_all <= 1'b0;
      req_addr      <= '0;
      req_blk       <= '0;
      req_data      <= '0;
      erase_mask    <= '0;
    end else begin
      req_prog      <= 1'b0;
      req_blk_erase <= 1'b0;
      req_lock_prog <= 1'b0;
      req_erase_all <= 1'b0;
      erase_mask    <= '0;
      if (prog_fail)  err_prog  <= 1'b1;
      if (erase_fail) err_erase <= 1'b1;
      if (accept) begin
        if (pend_q == PD_NONE) begin
          case (code)
            OP_RD_ARRAY: mode <= RM_ARRAY;
            OP_RD_STAT:  mode <= RM_STATUS;
            OP_RD_LOCK:  mode <= RM_LOCK;
            OP_CLR_STAT: begin
              err_prog  <= 1'b0;
              err_erase <= 1'b0;
            end
            OP_PROG: begin
              pend_q      <= PD_PROG;
              pend_addr_q <= addr;
            end
            OP_BERASE:   pend_q <= PD_BERASE;
            OP_LOCKPROG: pend_q <= PD_LOCK;
            OP_EALL:     pend_q <= PD_EALL;
            default: ;
          endcase
        end else begin
          pend_q   <= PD_NONE;
          mode     <= RM_ARRAY;
          req_addr <= addr;
          req_blk  <= blk;
          if (pend_q == PD_PROG) begin
            if (addr == pend_addr_q) begin
              req_prog <= 1'b1;
              req_data <= wdata;
            end else begin
              err_prog <= 1'b1;
            end
          end else if (code != OP_CONFIRM) begin
            err_prog  <= 1'b1;
            err_erase <= 1'b1;
          end else begin
            case (pend_q)
              PD_BERASE: req_blk_erase <= 1'b1;
              PD_LOCK:   req_lock_prog <= 1'b1;
              PD_EALL: begin
                req_erase_all <= 1'b1;
                erase_mask    <= eligible;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd,
  input  logic        rd_ok,
  input  rd_mode_e    mode,
  input  logic [15:0] arr_word,
  input  logic [7:0]  status,
  input  logic        lock_bit,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd && rd_ok;
      if (rd && rd_ok) begin
        case (mode)
          RM_ARRAY:  rd_data <= arr_word;
          RM_STATUS: rd_data <= {8'h00, status};
          default:   rd_data <= {15'b0, lock_bit};
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK   = 14,
  parameter int BLK_SHIFT = 8,
  parameter int PROT_BLK  = NUM_BLK - 1,
  localparam int BIDX_W   = $clog2(NUM_BLK),
  localparam int ADDR_W   = BLK_SHIFT + BIDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic               rd_valid,
  output logic [15:0]        rd_data,
  output logic [ADDR_W-1:0]  arr_raddr,
  input  logic [15:0]        arr_rdata,
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic               be_busy,
  input  logic               be_prog_fail,
  input  logic               be_erase_fail,
  output logic               req_prog,
  output logic               req_blk_erase,
  output logic               req_lock_prog,
  output logic               req_erase_all,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BIDX_W-1:0]  req_blk,
  output logic [15:0]        req_data,
  output logic [NUM_BLK-1:0] erase_mask,
  output logic [1:0]         err_flags
);
  logic              a_ok;
  logic [BIDX_W-1:0] a_blk;
  rd_mode_e          mode;
  logic              err_prog;
  logic              err_erase;
  logic [7:0]        status;

  assign arr_raddr = bus_addr;
  assign status    = {!be_busy, 1'b0, err_erase, err_prog, 4'b0000};
  assign err_flags = {err_erase, err_prog};

  flash_addr_dec #(
    .NUM_BLK(NUM_BLK), .BLK_SHIFT(BLK_SHIFT), .BIDX_W(BIDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr), .ok(a_ok), .blk(a_blk)
  );

  flash_seq_fsm #(
    .NUM_BLK(NUM_BLK), .BIDX_W(BIDX_W), .ADDR_W(ADDR_W), .PROT_BLK(PROT_BLK)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr(bus_wr), .wr_ok(a_ok), .addr(bus_addr),
    .blk(a_blk), .wdata(bus_wdata), .busy(be_busy), .lock_bits(lock_bits),
    .prog_fail(be_prog_fail), .erase_fail(be_erase_fail), .mode(mode),
    .err_prog(err_prog), .err_erase(err_erase), .req_prog(req_prog),
    .req_blk_erase(req_blk_erase), .req_lock_prog(req_lock_prog),
    .req_erase_all(req_erase_all), .req_addr(req_addr), .req_blk(req_blk),
    .req_data(req_data), .erase_mask(erase_mask)
  );

  flash_rd_mux u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .rd_ok(a_ok), .mode(mode),
    .arr_word(arr_rdata), .status(status), .lock_bit(lock_bits[a_blk]),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
  parameter int NUM_BLK  = 14,
  parameter int PROT_BLK = NUM_BLK - 1,
  parameter int ADDR_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               rd_valid,
  input logic [NUM_BLK-1:0] lock_bits,
  input logic               be_busy,
  input logic               req_prog,
  input logic               req_blk_erase,
  input logic               req_lock_prog,
  input logic               req_erase_all,
  input logic [NUM_BLK-1:0] erase_mask
);
  logic any_req;
  assign any_req = req_prog | req_blk_erase | req_lock_prog | req_erase_all;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_prog, req_blk_erase, req_lock_prog, req_erase_all})); // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    any_req |=> !any_req); // R8
  AST_MASK_PROT: assert property (@(posedge clk) disable iff (rst)
    req_erase_all |-> !erase_mask[PROT_BLK]); // R9
  AST_MASK_LOCK: assert property (@(posedge clk) disable iff (rst)
    req_erase_all |-> ((erase_mask & $past(lock_bits)) == '0)); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    be_busy |=> !any_req); // R12
  AST_ODD_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[0]) |=> !rd_valid); // R1
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd)); // R3
endmodule

bind flash_cmd_if flash_cmd_if_chk #(
  .NUM_BLK(NUM_BLK), .PROT_BLK(PROT_BLK), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  localparam int NB = 6;
  localparam int BS = 4;
  localparam int AW = 7;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata;
  logic rd_valid;
  logic [15:0] rd_data;
  logic [AW-1:0] arr_raddr;
  logic [15:0] arr_rdata;
  logic [NB-1:0] lock_bits;
  logic be_busy, be_prog_fail, be_erase_fail;
  logic req_prog, req_blk_erase, req_lock_prog, req_erase_all;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_blk;
  logic [15:0] req_data;
  logic [NB-1:0] erase_mask;
  logic [1:0] err_flags;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] arr_word(input logic [AW-1:0] a);
    return 16'hC300 ^ {9'b0, a};
  endfunction
  assign arr_rdata = arr_word(arr_raddr);

  flash_cmd_if #(.NUM_BLK(NB), .BLK_SHIFT(BS)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .lock_bits(lock_bits),
    .be_busy(be_busy), .be_prog_fail(be_prog_fail), .be_erase_fail(be_erase_fail),
    .req_prog(req_prog), .req_blk_erase(req_blk_erase), .req_lock_prog(req_lock_prog),
    .req_erase_all(req_erase_all), .req_addr(req_addr), .req_blk(req_blk),
    .req_data(req_data), .erase_mask(erase_mask), .err_flags(err_flags)
  );

  typedef struct {
    int            kind;  // 0 read, 1 prog, 2 block erase, 3 lock prog, 4 erase all
    logic [15:0]   d;
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    logic [NB-1:0] m;
    string         tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [15:0] d, input logic [AW-1:0] a,
                      input logic [BW-1:0] b, input logic [NB-1:0] m, input string tag);
    item_t it;
    it.kind = kind; it.d = d; it.a = a; it.b = b; it.m = m; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    push(0, exp, a, '0, '0, tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_ign(input logic [AW-1:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pops one expected item for every observed output event.
  always @(negedge clk) begin
    if (!rst) begin
      int k;
      item_t e;
      bit bad;
      k = -1;
      if (rd_valid) k = 0;
      else if (req_prog) k = 1;
      else if (req_blk_erase) k = 2;
      else if (req_lock_prog) k = 3;
      else if (req_erase_all) k = 4;
      if (k >= 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected output event (R1 R12 R13)", k, 32'hFFFF);
        end else begin
          e = exp_q.pop_front();
          bad = (k != e.kind);
          case (e.kind)
            0: bad = bad || (rd_data !== e.d);
            1: bad = bad || (req_addr !== e.a) || (req_data !== e.d);
            2, 3: bad = bad || (req_addr !== e.a) || (req_blk !== e.b);
            default: bad = bad || (erase_mask !== e.m);
          endcase
          chk(!bad, e.tag, {k[3:0], 12'h0, (k == 0) ? rd_data :
                            (k == 1) ? req_data : (k == 4) ? {10'b0, erase_mask} : {13'b0, req_blk}},
              {e.kind[3:0], 12'h0, (e.kind == 4) ? {10'b0, e.m} :
                            (e.kind >= 2) ? {13'b0, e.b} : e.d});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    lock_bits = 6'b000101; be_busy = 0; be_prog_fail = 0; be_erase_fail = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(!rd_valid && !req_prog && !req_blk_erase && !req_lock_prog && !req_erase_all,
        "R3 reset strobes", 0, 0);
    chk(err_flags == 2'b00, "R5 reset err_flags", err_flags, 0);

    rd(7'h12, arr_word(7'h12), "R3 array read after reset");
    rd(7'h34, arr_word(7'h34), "R3 array mode held");

    rd_ign(7'h13);                       // R1 odd read: no event
    wr(7'h13, 16'h0070);                 // R1 odd write ignored
    wr(7'h60, 16'h0070);                 // R1 block 6 out of range
    rd(7'h20, arr_word(7'h20), "R1 ignored writes keep array mode");

    wr(7'h20, 16'hAB70);
    rd(7'h10, 16'h0080, "R2 R4 status with junk high byte");
    rd(7'h44, 16'h0080, "R4 status mode held");
    wr(7'h00, 16'h00FF);
    rd(7'h02, arr_word(7'h02), "R3 back to array");

    wr(7'h22, 16'h0040);
    push(1, 16'hBEEF, 7'h22, 3'd2, '0, "R6 program request");
    wr(7'h22, 16'hBEEF);
    wr(7'h22, 16'h0040);
    wr(7'h24, 16'h1234);
    chk(err_flags == 2'b01, "R6 address mismatch program error", err_flags, 2'b01);
    wr(7'h00, 16'h0070);
    rd(7'h00, 16'h0090, "R4 status shows program error");
    wr(7'h00, 16'h0050);
    chk(err_flags == 2'b00, "R5 clear status", err_flags, 0);
    rd(7'h00, 16'h0080, "R5 clear leaves status mode");

    wr(7'h50, 16'h0020);
    push(2, 16'h0, 7'h5E, 3'd5, '0, "R7 block erase of protected block");
    wr(7'h5E, 16'h00D0);
    rd(7'h30, arr_word(7'h30), "R14 completion returns array mode");

    wr(7'h20, 16'h0077);
    push(3, 16'h0, 7'h2E, 3'd2, '0, "R8 lock program");
    wr(7'h2E, 16'h00D0);

    wr(7'h00, 16'h00A7);
    push(4, 16'h0, 7'h00, 3'd0, 6'b011010, "R9 erase-all mask");
    wr(7'h00, 16'h00D0);

    wr(7'h00, 16'h0070);
    wr(7'h00, 16'h0020);
    wr(7'h0E, 16'h00D1);
    chk(err_flags == 2'b11, "R10 bad confirm error bits", err_flags, 2'b11);
    rd(7'h0E, arr_word(7'h0E), "R10 bad confirm returns array mode");

    wr(7'h10, 16'h0077);
    push(3, 16'h0, 7'h1E, 3'd1, '0, "R2 confirm with junk high byte");
    wr(7'h1E, 16'h55D0);

    wr(7'h00, 16'h0071);
    rd(7'h00, 16'h0001, "R11 lock bit block 0");
    rd(7'h10, 16'h0000, "R11 lock bit block 1");
    rd(7'h24, 16'h0001, "R11 lock bit block 2");
    wr(7'h00, 16'h0033);
    wr(7'h00, 16'h00D0);
    rd(7'h2A, 16'h0001, "R13 undefined codes keep lock mode");

    be_busy = 1'b1;
    wr(7'h00, 16'h00FF);
    rd(7'h02, 16'h0001, "R12 write ignored while busy");
    be_busy = 1'b0;
    wr(7'h00, 16'h0070);
    be_busy = 1'b1;
    rd(7'h00, 16'h0030, "R12 ready bit low while busy");
    wr(7'h00, 16'h0040);
    wr(7'h00, 16'h0040);
    be_busy = 1'b0;
    rd(7'h00, 16'h00B0, "R12 R4 ready bit high when idle");

    wr(7'h00, 16'h0050);
    be_erase_fail = 1'b1;
    @(negedge clk);
    be_erase_fail = 1'b0;
    chk(err_flags == 2'b10, "R5 erase failure sets erase bit", err_flags, 2'b10);
    be_prog_fail = 1'b1;
    @(negedge clk);
    be_prog_fail = 1'b0;
    chk(err_flags == 2'b11, "R5 program failure sets program bit", err_flags, 2'b11);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 R7 R8 R9 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule